// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Break Handling

This block receives asynchronous serial frames on a single line. A sample enable (`tick16`) pulses at sixteen times the bit rate. The receiver finds the start bit on that enable, samples every later bit at its centre, and builds frames of eight data bits, least significant bit first. A parity bit, odd or even, can follow the data. One stop bit ends each frame. Each completed byte goes into a holding register and sets `rx_full`. Software empties the register with a read strobe.

Three sticky error flags record overrun, parity mismatch and a low stop bit. They stay set until software clears them through a masked write strobe. Dropping the receive enable does not clear them.

The synchronised level of the receive line is also available as an output. Software can read it after a framing error: a line that is still low means a break, not a corrupted frame. The receiver keeps running during a break. A framing flag that software clears while the line stays low is therefore set again by the next all-zero frame.

Top module: `serial_rx_core`

## Requirements
- R1: `line_level` equals `rxd` delayed by two clock cycles through a two-stage synchroniser. It is 1 during and straight after reset.
- R2: When idle with `rx_en` high, the first `tick16` on which `line_level` is 0 starts a frame. Each bit is sampled on the 8th `tick16` counted from that detection tick. Bit samples are 16 ticks apart.
- R3: If the start bit reads 1 at its centre sample, the receiver returns to idle. It delivers no byte and sets no flag.
- R4: The receiver samples eight data bits, least significant first. When `parity_en` is 1, a parity bit follows them. The stop bit comes last.
- R5: On the clock after the stop sample, if the holding register is empty or `rd_strobe` is high in that cycle, `rx_data` takes the byte and `rx_full` is 1. A read in the completing cycle causes no overrun.
- R6: `rd_strobe` clears `rx_full` unless a frame completes in the same cycle. After reset, `rx_full`, `rx_data` and all flags are 0.
- R7: If a frame completes while `rx_full` is 1 and there is no read, `err_ovr` is set and `rx_data` keeps the earlier byte.
- R8: With `parity_en` high, `err_par` is set when the count of ones in the data and parity bits is odd for `parity_odd`=0, or even for `parity_odd`=1.
- R9: A stop bit sampled as 0 sets `err_frm`, and the byte is still delivered under R5/R7.
- R10: While `rxd` is held at 0, frames keep completing with data 0x00. Each one sets `err_frm`. With odd parity each one also sets `err_par`. A cleared `err_frm` is set again by the next such frame, and `line_level` reads 0.
- R11: A cycle with `err_clr_we` high clears the flags selected in `err_clr_mask`: bit 0 is overrun, bit 1 is parity, bit 2 is framing. If a flag is set and cleared in the same cycle, it ends up set.
- R12: `rx_en` low aborts any frame and holds the receiver idle. The flags, `rx_data` and `rx_full` are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample enable at 16x bit rate |
| rx_en | input | 1 | Receive enable |
| parity_en | input | 1 | Expect a parity bit after the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| rxd | input | 1 | Asynchronous serial input |
| rd_strobe | input | 1 | Software read of the holding register |
| err_clr_we | input | 1 | Error flag clear strobe |
| err_clr_mask | input | 3 | Flags to clear: bit0 overrun, bit1 parity, bit2 framing |
| rx_data | output | 8 | Received byte |
| rx_full | output | 1 | Holding register contains an unread byte |
| err_ovr | output | 1 | Sticky overrun flag |
| err_par | output | 1 | Sticky parity error flag |
| err_frm | output | 1 | Sticky framing error flag |
| line_level | output | 1 | Synchronised receive line level |

## Verification
Two events can fall in the same clock: a frame completing and a software access to the status. The completion can coincide with a read of a full holding register, and it can coincide with a clear strobe aimed at the flag that the frame is setting.

The bench provokes this case directly. Its behavioural model predicts the exact cycle of the stop-bit sample. The bench then raises the read strobe and the full clear mask in that one cycle, during a frame whose stop bit is low.

The expected result is:
- `rx_full` stays at 1 and holds the new byte.
- `err_ovr` stays clear.
- `err_frm` ends up set.

The model also compares every output on every clock, so the ordering of any other coincidence is judged as well.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Mask bit positions for the clear strobe.
    localparam int FLG_OVR = 0;
    localparam int FLG_PAR = 1;
    localparam int FLG_FRM = 2;
    localparam int FLG_NUM = 3;

    typedef struct packed {
        logic frm;
        logic par;
        logic ovr;
    } err_flags_t;

endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    // The line idles high, so reset fills the chain with ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 rx_en,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    output logic                 frame_done,
    output logic [DATA_BITS-1:0] frame_data,
    output logic                 frame_perr,
    output logic                 frame_ferr
);

    localparam int PH_W  = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [PH_W-1:0]  PH_MID   = PH_W'(OVS / 2 - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e             state;
        logic [PH_W-1:0]       phase;
        logic [BIT_W-1:0]      bit_idx;
        logic [DATA_BITS-1:0]  shift;
        logic                  par_acc;
        logic                  par_bad;
    } fsm_t;

    fsm_t q, d;
    logic done_c;
    logic ferr_c;

    always_comb begin
        d      = q;
        done_c = 1'b0;
        ferr_c = 1'b0;
        if (!rx_en) begin
            d.state = ST_IDLE;
            d.phase = '0;
        end else if (tick) begin
            if (q.state == ST_IDLE) begin
                // A low line while idle is the sampled start edge.
                if (!line) begin
                    d.state = ST_START;
                    d.phase = '0;
                end
            end else begin
                d.phase = (q.phase == PH_LAST) ? '0 : q.phase + 1'b1;
                if (q.phase == PH_MID) begin
                    case (q.state)
                        ST_START: begin
                            if (line) begin
                                d.state = ST_IDLE;
                            end else begin
                                d.state   = ST_DATA;
                                d.bit_idx = '0;
                                d.par_acc = 1'b0;
                                d.par_bad = 1'b0;
                            end
                        end
                        ST_DATA: begin
                            d.shift   = {line, q.shift[DATA_BITS-1:1]};
                            d.par_acc = q.par_acc ^ line;
                            if (q.bit_idx == BIT_LAST) begin
                                d.state = parity_en ? ST_PAR : ST_STOP;
                            end else begin
                                d.bit_idx = q.bit_idx + 1'b1;
                            end
                        end
                        ST_PAR: begin
                            d.par_bad = (q.par_acc ^ line) != parity_odd;
                            d.state   = ST_STOP;
                        end
                        ST_STOP: begin
                            done_c  = 1'b1;
                            ferr_c  = ~line;
                            d.state = ST_IDLE;
                        end
                        default: d.state = ST_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, phase: '0, bit_idx: '0, shift: '0,
                   par_acc: 1'b0, par_bad: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign frame_done = done_c;
    assign frame_data = q.shift;
    assign frame_perr = q.par_bad;
    assign frame_ferr = ferr_c;

endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  logic [DATA_BITS-1:0] frame_data,
    input  logic                 frame_perr,
    input  logic                 frame_ferr,
    input  logic                 rd_strobe,
    input  logic                 clr_we,
    input  logic [FLG_NUM-1:0]   clr_mask,
    output logic [DATA_BITS-1:0] hold_data,
    output logic                 hold_full,
    output err_flags_t           flags
);

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 full;
        err_flags_t           err;
    } stat_t;

    stat_t q, d;

    always_comb begin
        d = q;
        // A read in the same cycle frees the register first.
        if (rd_strobe) d.full = 1'b0;
        if (clr_we) begin
            if (clr_mask[FLG_OVR]) d.err.ovr = 1'b0;
            if (clr_mask[FLG_PAR]) d.err.par = 1'b0;
            if (clr_mask[FLG_FRM]) d.err.frm = 1'b0;
        end
        // Setting comes last so it wins over a clear.
        if (frame_done) begin
            if (d.full) begin
                d.err.ovr = 1'b1;
            end else begin
                d.data = frame_data;
                d.full = 1'b1;
            end
            if (frame_perr) d.err.par = 1'b1;
            if (frame_ferr) d.err.frm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hold_data = q.data;
    assign hold_full = q.full;
    assign flags     = q.err;

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 rx_en,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic                 rxd,
    input  logic                 rd_strobe,
    input  logic                 err_clr_we,
    input  logic [2:0]           err_clr_mask,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 err_ovr,
    output logic                 err_par,
    output logic                 err_frm,
    output logic                 line_level
);

    logic                 line_s;
    logic                 frm_done;
    logic [DATA_BITS-1:0] frm_data;
    logic                 frm_perr;
    logic                 frm_ferr;
    err_flags_t           flags;

    srx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    srx_frame_fsm #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .line      (line_s),
        .rx_en     (rx_en),
        .parity_en (parity_en),
        .parity_odd(parity_odd),
        .frame_done(frm_done),
        .frame_data(frm_data),
        .frame_perr(frm_perr),
        .frame_ferr(frm_ferr)
    );

    srx_status #(.DATA_BITS(DATA_BITS)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_done(frm_done),
        .frame_data(frm_data),
        .frame_perr(frm_perr),
        .frame_ferr(frm_ferr),
        .rd_strobe (rd_strobe),
        .clr_we    (err_clr_we),
        .clr_mask  (err_clr_mask),
        .hold_data (rx_data),
        .hold_full (rx_full),
        .flags     (flags)
    );

    assign err_ovr    = flags.ovr;
    assign err_par    = flags.par;
    assign err_frm    = flags.frm;
    assign line_level = line_s;

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 rd_strobe,
    input logic                 err_clr_we,
    input logic [2:0]           err_clr_mask,
    input logic                 frame_done,
    input logic [DATA_BITS-1:0] frame_data,
    input logic                 frame_ferr,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_full,
    input logic                 err_ovr,
    input logic                 err_par,
    input logic                 err_frm
);

    AST_FILL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !(rx_full && !rd_strobe) |=> rx_full && rx_data == $past(frame_data)); // R5

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !frame_done |=> !rx_full); // R6

    AST_OVR_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> rx_full); // R7

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !rd_strobe |=> $stable(rx_data)); // R7

    AST_FERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && frame_ferr |=> err_frm); // R9

    AST_CLR_FRM: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_we && err_clr_mask[2] && !frame_done |=> !err_frm); // R11

    AST_RXEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en && !err_clr_we |=> $stable({err_ovr, err_par, err_frm})); // R12

endmodule

bind serial_rx_core srx_checker #(.DATA_BITS(DATA_BITS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .rd_strobe   (rd_strobe),
    .err_clr_we  (err_clr_we),
    .err_clr_mask(err_clr_mask),
    .frame_done  (frm_done),
    .frame_data  (frm_data),
    .frame_ferr  (frm_ferr),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .err_ovr     (err_ovr),
    .err_par     (err_par),
    .err_frm     (err_frm)
);

// File: tb/serial_rx_core_tb_top.sv
`timescale 1ns/1ps
module serial_rx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic       rx_en = 1'b0;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       err_clr_we = 1'b0;
    logic [2:0] err_clr_mask = 3'b000;
    logic [7:0] rx_data;
    logic       rx_full, err_ovr, err_par, err_frm, line_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [1:0] tk_cnt = 2'd0;

    always #4 clk = ~clk;

    serial_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en),
        .parity_en(parity_en), .parity_odd(parity_odd), .rxd(rxd),
        .rd_strobe(rd_strobe), .err_clr_we(err_clr_we), .err_clr_mask(err_clr_mask),
        .rx_data(rx_data), .rx_full(rx_full), .err_ovr(err_ovr),
        .err_par(err_par), .err_frm(err_frm), .line_level(line_level)
    );

    // Sample enable: one clock in four, changing only on falling edges.
    initial forever begin
        @(negedge clk);
        tk_cnt = tk_cnt + 2'd1;
    end
    assign tick16 = (tk_cnt == 2'd3);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on each rising edge.
    int m_s1, m_s2, m_state, m_ph, m_cnt, m_ones, m_pbad;
    logic [7:0] m_byte, m_data;
    int m_full, m_ovr, m_par, m_frm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_state = 0; m_ph = 0; m_cnt = 0; m_ones = 0;
            m_pbad = 0; m_byte = 8'h00; m_data = 8'h00;
            m_full = 0; m_ovr = 0; m_par = 0; m_frm = 0;
        end else begin
            int ln, done, fe, pe;
            ln = m_s2; done = 0; fe = 0; pe = 0;
            if (!rx_en) begin
                m_state = 0;
            end else if (tick16) begin
                if (m_state == 0) begin
                    if (ln == 0) begin m_state = 1; m_ph = 0; end
                end else begin
                    if (m_ph == 7) begin
                        case (m_state)
                            1: if (ln != 0) m_state = 0;
                               else begin m_state = 2; m_cnt = 0; m_ones = 0; m_pbad = 0; end
                            2: begin
                                m_byte[m_cnt] = ln[0];
                                m_ones += ln;
                                m_cnt++;
                                if (m_cnt == 8) m_state = parity_en ? 3 : 4;
                            end
                            3: begin
                                m_pbad = (((m_ones + ln) % 2) != int'(parity_odd)) ? 1 : 0;
                                m_state = 4;
                            end
                            default: begin
                                done = 1; fe = (ln == 0) ? 1 : 0; pe = m_pbad; m_state = 0;
                            end
                        endcase
                    end
                    m_ph = (m_ph + 1) % 16;
                end
            end
            if (rd_strobe) m_full = 0;
            if (err_clr_we) begin
                if (err_clr_mask[0]) m_ovr = 0;
                if (err_clr_mask[1]) m_par = 0;
                if (err_clr_mask[2]) m_frm = 0;
            end
            if (done != 0) begin
                if (m_full != 0) m_ovr = 1;
                else begin m_data = m_byte; m_full = 1; end
                if (pe != 0) m_par = 1;
                if (fe != 0) m_frm = 1;
            end
            m_s2 = m_s1;
            m_s1 = int'(rxd);
        end
    end

    // Clock-by-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 line_level", 32'(line_level), 32'(m_s2));
            check("R5 rx_data", 32'(rx_data), 32'(m_data));
            check("R6 rx_full", 32'(rx_full), 32'(m_full));
            check("R7 err_ovr", 32'(err_ovr), 32'(m_ovr));
            check("R8 err_par", 32'(err_par), 32'(m_par));
            check("R9 err_frm", 32'(err_frm), 32'(m_frm));
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit with_par,
                              input bit pbit, input bit stop_bit);
        rxd = 1'b0; wait_clk(64);
        for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_clk(64); end
        if (with_par) begin rxd = pbit; wait_clk(64); end
        rxd = stop_bit;
        wait_clk(stop_bit ? 64 : 44);
        rxd = 1'b1;
        wait_clk(100);
    endtask

    task automatic read_byte();
        rd_strobe = 1'b1; wait_clk(1); rd_strobe = 1'b0;
    endtask

    task automatic clear_flags(input logic [2:0] m);
        err_clr_we = 1'b1; err_clr_mask = m; wait_clk(1);
        err_clr_we = 1'b0; err_clr_mask = 3'b000;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(1);
        // Reset state (R1, R6)
        check("R1 reset line", 32'(line_level), 32'd1);
        check("R6 reset full", 32'(rx_full), 32'd0);
        check("R6 reset flags", 32'({err_ovr, err_par, err_frm}), 32'd0);
        rx_en = 1'b1;
        wait_clk(20);

        // R2 R4 R5: plain frame
        send_frame(8'hA5, 0, 0, 1);
        check("R4 data A5", 32'(rx_data), 32'hA5);
        check("R5 full after frame", 32'(rx_full), 32'd1);
        read_byte();
        check("R6 read clears full", 32'(rx_full), 32'd0);

        // R3: short low pulse is a glitch
        rxd = 1'b0; wait_clk(16); rxd = 1'b1; wait_clk(1000);
        check("R3 glitch no byte", 32'(rx_full), 32'd0);
        check("R3 glitch no flag", 32'({err_ovr, err_par, err_frm}), 32'd0);

        // R8: even parity, right then wrong
        parity_en = 1'b1; parity_odd = 1'b0;
        send_frame(8'h3C, 1, 0, 1);
        check("R8 good parity", 32'(err_par), 32'd0);
        check("R2 parity frame data", 32'(rx_data), 32'h3C);
        read_byte();
        send_frame(8'h3C, 1, 1, 1);
        check("R8 bad parity", 32'(err_par), 32'd1);
        read_byte();
        parity_en = 1'b0;

        // R9 framing, then R7 overrun
        send_frame(8'h5A, 0, 0, 0);
        check("R9 framing set", 32'(err_frm), 32'd1);
        check("R9 byte delivered", 32'(rx_data), 32'h5A);
        send_frame(8'hC3, 0, 0, 1);
        check("R7 overrun set", 32'(err_ovr), 32'd1);
        check("R7 data kept", 32'(rx_data), 32'h5A);

        // R12: receive disabled mid-frame
        rxd = 1'b0; wait_clk(64);
        rxd = 1'b1; wait_clk(64);
        rxd = 1'b0; wait_clk(64);
        rx_en = 1'b0; rxd = 1'b1; wait_clk(800);
        rx_en = 1'b1; wait_clk(200);
        check("R12 flags kept", 32'({err_ovr, err_par, err_frm}), 32'h7);
        check("R12 data kept", 32'(rx_data), 32'h5A);
        check("R12 full kept", 32'(rx_full), 32'd1);

        // R11: selective clears
        clear_flags(3'b100);
        check("R11 frm cleared", 32'(err_frm), 32'd0);
        check("R11 ovr untouched", 32'(err_ovr), 32'd1);
        clear_flags(3'b011);
        check("R11 all clear", 32'({err_ovr, err_par, err_frm}), 32'd0);
        read_byte();

        // R10: break with odd parity
        parity_en = 1'b1; parity_odd = 1'b1;
        rxd = 1'b0; wait_clk(720);
        check("R10 break framing", 32'(err_frm), 32'd1);
        check("R10 break parity", 32'(err_par), 32'd1);
        check("R10 break data", 32'(rx_data), 32'h00);
        check("R1 line low in break", 32'(line_level), 32'd0);
        clear_flags(3'b111);
        check("R11 cleared in break", 32'(err_frm), 32'd0);
        wait_clk(720);
        check("R10 framing sets again", 32'(err_frm), 32'd1);
        rxd = 1'b1; wait_clk(1500);
        parity_en = 1'b0; parity_odd = 1'b0;
        read_byte();
        clear_flags(3'b111);
        wait_clk(10);

        // R5 R11: read and clear coincide with a completing frame
        send_frame(8'hA5, 0, 0, 1);
        check("R5 full before collision", 32'(rx_full), 32'd1);
        fork
            send_frame(8'h96, 0, 0, 0);
            begin
                bit hit;
                hit = 0;
                for (int k = 0; k < 2000 && !hit; k++) begin
                    @(negedge clk); #1;
                    if (m_state == 4 && m_ph == 7 && tick16 && rx_en) begin
                        rd_strobe = 1'b1; err_clr_we = 1'b1; err_clr_mask = 3'b111;
                        @(negedge clk);
                        check("R5 collision full", 32'(rx_full), 32'd1);
                        check("R5 collision data", 32'(rx_data), 32'h96);
                        check("R5 collision no overrun", 32'(err_ovr), 32'd0);
                        check("R11 set wins over clear", 32'(err_frm), 32'd1);
                        rd_strobe = 1'b0; err_clr_we = 1'b0; err_clr_mask = 3'b000;
                        hit = 1;
                    end
                end
                check("R5 collision reached", 32'(hit), 32'd1);
            end
        join
        wait_clk(20);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule